// File: doc/BRIEF.md
# Level Interrupt Router with Two Output Classes

This block gathers 32 level-sensitive interrupt request lines and turns them into two processor-facing requests: a normal request and a fast request. Software chooses, per line, which of the two a line drives and whether the line is allowed through at all. A line keeps its request up for as long as the peripheral holds it, and the peripheral clears it. Nothing is latched here.

Software reaches the block through a small word-addressed register bus. It can read the raw line levels, the per-class masked status and the configuration. Enables are never written as a whole word. A write to the set window enables every line whose data bit is one. A write to the clear window disables every line whose data bit is one. Bits written as zero leave their lines as they were. An optional lock lets only privileged bus writes change the configuration.

Top module: `intr_steer_ctrl`

## Requirements
- R1: A read at word offset 2 returns the current levels of `src_lvl`, one bit per line, before any masking.
- R2: A read at offset 0 returns `src_lvl & enable & ~select`. A read at offset 1 returns `src_lvl & enable & select`.
- R3: Offset 3 holds the select word. It reads back what was written. A 1 in a bit routes that line to the fast class and a 0 routes it to the normal class.
- R4: Writing offset 4 sets each enable bit whose data bit is 1 and leaves the others unchanged. A read at offset 4 returns the enable mask.
- R5: Writing offset 5 clears each enable bit whose data bit is 1 and leaves the others unchanged. Writing all ones disables every line. Offset 5 reads as zero.
- R6: `irq_o` is the OR of the offset-0 status and `fiq_o` is the OR of the offset-1 status. Each is taken from a register, so it follows the status one clock later.
- R7: Bit 0 at offset 8 is the write lock. While it is 1, a write with `bus_priv` low changes nothing, including the lock itself. A write with `bus_priv` high still takes effect.
- R8: Writes to offsets 0, 1 and 2 change no state. Reads at unmapped offsets (6, 7 and 9 to 15) return zero.
- R9: After reset the enable mask, the select word and the lock are zero, and `irq_o` and `fiq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lvl | input | 32 | Interrupt request levels, one per line |
| bus_addr | input | 4 | Word offset of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | High for a privileged access |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered normal-class request |
| fiq_o | output | 1 | Registered fast-class request |

## Verification
The assertions assume that a write strobe is a single-cycle pulse with a stable address and data in that cycle, and that every input is at a known value once reset has been released. They also assume that `src_lvl` changes only between clock edges. The bench drives every input on the falling edge and holds it for a full cycle. It raises `bus_wr` for exactly one rising edge per write, so each access lands cleanly within those assumptions.

// File: rtl/intr_steer_pkg.sv
// Shared constants for the interrupt router: line count, bus address width
// and the word offsets of each register window.
package intr_steer_pkg;
    localparam int NSRC   = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_NSTAT = 4'd0;  // normal-class masked status
    localparam logic [ADDR_W-1:0] OFF_FSTAT = 4'd1;  // fast-class masked status
    localparam logic [ADDR_W-1:0] OFF_RAW   = 4'd2;  // unmasked line levels
    localparam logic [ADDR_W-1:0] OFF_SEL   = 4'd3;  // class select word
    localparam logic [ADDR_W-1:0] OFF_ESET  = 4'd4;  // enable set / mask readback
    localparam logic [ADDR_W-1:0] OFF_ECLR  = 4'd5;  // enable clear
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 4'd8;  // write lock, bit 0
endpackage

// File: rtl/intr_cfg_regs.sv
// Configuration state: enable mask, class select word and write lock.
// Assumes one access per cycle, with bus_wr qualifying bus_addr and bus_wdata.
// Enables change only through the set and clear windows. A locked,
// unprivileged write is dropped in full.
module intr_cfg_regs
    import intr_steer_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [NS-1:0] bus_wdata,
    input  logic          bus_priv,
    output logic [NS-1:0] en_mask,
    output logic [NS-1:0] sel_mask,
    output logic          lock_on
);
    logic wr_ok;

    // Gate writes: a locked block accepts only privileged writes.
    always_comb wr_ok = bus_wr && (!lock_on || bus_priv);

    // Enable mask: set and clear windows, one bit per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else if (wr_ok && bus_addr == OFF_ESET[AW-1:0]) begin
            en_mask <= en_mask | bus_wdata;
        end else if (wr_ok && bus_addr == OFF_ECLR[AW-1:0]) begin
            en_mask <= en_mask & ~bus_wdata;
        end
    end

    // Select word and lock bit: plain whole-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_mask <= '0;
            lock_on  <= 1'b0;
        end else if (wr_ok) begin
            if (bus_addr == OFF_SEL[AW-1:0])  sel_mask <= bus_wdata;
            if (bus_addr == OFF_LOCK[AW-1:0]) lock_on  <= bus_wdata[0];
        end
    end

    a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (!lock_on || bus_priv) && bus_addr == OFF_ESET[AW-1:0])
        |=> ((en_mask & $past(bus_wdata)) == $past(bus_wdata)));

    a_r4_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ESET[AW-1:0])
        |=> ((en_mask & ~$past(bus_wdata)) == ($past(en_mask) & ~$past(bus_wdata))));

    a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (!lock_on || bus_priv) && bus_addr == OFF_ECLR[AW-1:0])
        |=> ((en_mask & $past(bus_wdata)) == '0));

    a_r5_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ECLR[AW-1:0])
        |=> ((en_mask | $past(bus_wdata)) == ($past(en_mask) | $past(bus_wdata))));

    a_r7_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lock_on && !bus_priv)
        |=> ($stable(en_mask) && $stable(sel_mask) && $stable(lock_on)));

    a_r8_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr <= OFF_RAW[AW-1:0])
        |=> ($stable(en_mask) && $stable(sel_mask) && $stable(lock_on)));
endmodule

// File: rtl/intr_route.sv
// Per-line steering and masking, followed by the registered OR of each class.
// Assumes src_lvl is already synchronous to clk. Each line is steered to its
// class first and then gated by its enable bit.
module intr_route
    import intr_steer_pkg::*;
#(
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] raw,
    input  logic [NS-1:0] en_mask,
    input  logic [NS-1:0] sel_mask,
    output logic [NS-1:0] nstat,
    output logic [NS-1:0] fstat,
    output logic          irq_o,
    output logic          fiq_o
);
    for (genvar i = 0; i < NS; i++) begin : g_line
        // Steer line i to one class, then apply its enable.
        always_comb begin
            nstat[i] = raw[i] & ~sel_mask[i] & en_mask[i];
            fstat[i] = raw[i] &  sel_mask[i] & en_mask[i];
        end
    end

    // Register the per-class request so the outputs are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |nstat;
            fiq_o <= |fstat;
        end
    end

    a_r2_classes_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (nstat & fstat) == '0);

    a_r2_status_within_raw: assert property (@(posedge clk) disable iff (!rst_n)
        ((nstat | fstat) & ~(raw & en_mask)) == '0);

    a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == ($past(raw & en_mask & ~sel_mask) != '0)));

    a_r6_fiq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == ($past(raw & en_mask & sel_mask) != '0)));
endmodule

// File: rtl/intr_rd_mux.sv
// Read data selection by word offset. Unmapped offsets and the clear
// window read as zero. Purely combinational. Assumes bus_addr is valid
// whenever bus_rdata is sampled.
module intr_rd_mux
    import intr_steer_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] bus_addr,
    input  logic [NS-1:0] raw,
    input  logic [NS-1:0] nstat,
    input  logic [NS-1:0] fstat,
    input  logic [NS-1:0] en_mask,
    input  logic [NS-1:0] sel_mask,
    input  logic          lock_on,
    output logic [NS-1:0] bus_rdata
);
    // Pick the register image that the offset names.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_NSTAT[AW-1:0]: bus_rdata = nstat;
            OFF_FSTAT[AW-1:0]: bus_rdata = fstat;
            OFF_RAW[AW-1:0]:   bus_rdata = raw;
            OFF_SEL[AW-1:0]:   bus_rdata = sel_mask;
            OFF_ESET[AW-1:0]:  bus_rdata = en_mask;
            OFF_LOCK[AW-1:0]:  bus_rdata = {{(NS-1){1'b0}}, lock_on};
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_steer_ctrl.sv
// Top of the interrupt router: configuration registers, per-line steering
// and the read mux. Assumes synchronous inputs and one bus access per cycle.
module intr_steer_ctrl
    import intr_steer_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src_lvl,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [NS-1:0] bus_wdata,
    input  logic          bus_priv,
    output logic [NS-1:0] bus_rdata,
    output logic          irq_o,
    output logic          fiq_o
);
    logic [NS-1:0] en_mask, sel_mask, nstat, fstat;
    logic          lock_on;

    intr_cfg_regs #(.NS(NS), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .en_mask(en_mask), .sel_mask(sel_mask), .lock_on(lock_on)
    );

    intr_route #(.NS(NS)) u_route (
        .clk(clk), .rst_n(rst_n), .raw(src_lvl), .en_mask(en_mask),
        .sel_mask(sel_mask), .nstat(nstat), .fstat(fstat),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    intr_rd_mux #(.NS(NS), .AW(AW)) u_rd (
        .bus_addr(bus_addr), .raw(src_lvl), .nstat(nstat), .fstat(fstat),
        .en_mask(en_mask), .sel_mask(sel_mask), .lock_on(lock_on),
        .bus_rdata(bus_rdata)
    );

    a_r9_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/intr_steer_ctrl_test.sv
// Directed bench for the interrupt router: one task per scenario.
module intr_steer_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    intr_steer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, logic p);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd4, v); chk("R9 enable", v, 32'h0);
        rd(4'd3, v); chk("R9 select", v, 32'h0);
        rd(4'd8, v); chk("R9 lock", v, 32'h0);
        chk("R9 outputs", {30'h0, irq_o, fiq_o}, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] v;
        @(negedge clk) src_lvl = 32'hA5A5_3C3C;
        rd(4'd2, v); chk("R1 raw", v, 32'hA5A5_3C3C);
        rd(4'd0, v); chk("R2 nothing enabled", v, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] v;
        wr(4'd4, 32'h0000_00F0, 1'b0);
        rd(4'd4, v); chk("R4 set", v, 32'h0000_00F0);
        wr(4'd4, 32'h0000_F000, 1'b0);
        rd(4'd4, v); chk("R4 zero bits keep", v, 32'h0000_F0F0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        wr(4'd3, 32'h0000_FF00, 1'b0);
        rd(4'd3, v); chk("R3 select readback", v, 32'h0000_FF00);
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk) src_lvl = 32'hFFFF_FFFF;
        rd(4'd0, v); chk("R2 normal status", v, 32'h0000_00F0);
        rd(4'd1, v); chk("R2 fast status", v, 32'h0000_F000);
        @(negedge clk);
        chk("R6 both high", {30'h0, irq_o, fiq_o}, 32'h3);
        // Only a fast line active: normal drops one edge later.
        src_lvl = 32'h0000_1000;
        #1 chk("R6 latency hold", {31'h0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R6 fast only", {30'h0, irq_o, fiq_o}, 32'h1);
        rd(4'd1, v); chk("R2 fast single", v, 32'h0000_1000);
        src_lvl = 32'h0000_0010;
        @(negedge clk);
        chk("R6 normal only", {30'h0, irq_o, fiq_o}, 32'h2);
        src_lvl = 32'h0000_0F00;
        @(negedge clk);
        chk("R6 disabled lines", {30'h0, irq_o, fiq_o}, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(4'd5, 32'h0000_0010, 1'b0);
        rd(4'd4, v); chk("R5 clear one", v, 32'h0000_F0E0);
        rd(4'd5, v); chk("R5 reads zero", v, 32'h0);
        wr(4'd5, 32'hFFFF_FFFF, 1'b0);
        rd(4'd4, v); chk("R5 clear all", v, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(4'd4, 32'h0000_0003, 1'b0);
        wr(4'd0, 32'hFFFF_FFFF, 1'b0);
        wr(4'd1, 32'hFFFF_FFFF, 1'b0);
        wr(4'd2, 32'hFFFF_FFFF, 1'b0);
        rd(4'd4, v); chk("R8 enable untouched", v, 32'h0000_0003);
        rd(4'd3, v); chk("R8 select untouched", v, 32'h0000_FF00);
        rd(4'd8, v); chk("R8 lock untouched", v, 32'h0);
        rd(4'd7, v); chk("R8 unmapped", v, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(4'd8, 32'h1, 1'b1);
        rd(4'd8, v); chk("R7 lock set", v, 32'h1);
        wr(4'd4, 32'h0000_00F0, 1'b0);
        rd(4'd4, v); chk("R7 unpriv set dropped", v, 32'h0000_0003);
        wr(4'd5, 32'hFFFF_FFFF, 1'b0);
        rd(4'd4, v); chk("R7 unpriv clear dropped", v, 32'h0000_0003);
        wr(4'd8, 32'h0, 1'b0);
        rd(4'd8, v); chk("R7 lock kept", v, 32'h1);
        wr(4'd4, 32'h0000_00F0, 1'b1);
        rd(4'd4, v); chk("R7 priv set", v, 32'h0000_00F3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw();
        t_set();
        t_select();
        t_status();
        t_clear();
        t_readonly();
        t_lock();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule